// File: doc/BRIEF.md
# Aging-Counter LRU Replacement Unit

This unit keeps recency state for every set of a set-associative cache and, when asked, names the way that has gone unused the longest. It holds no data, no tags and no memory traffic. The cache controller reports hits and fills with a set index and a way. When it needs room in a set, it raises a victim request with that set index. One cycle later the unit returns the victim way together with a valid flag.

For associativities above two, every way of every set holds a small saturating age counter. A touch, which is a hit or a fill, clears the counter of the touched way and ages every other way of that set. The victim is the oldest way. Because a touched way always ends with the smallest count in its set, a line that has just been filled cannot be chosen next. When the associativity is exactly two, the counters are dropped and each set keeps a single recency bit instead.

Top module: `lru_age_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all age counters and all recency bits are cleared. A victim request that follows reset, with no touch in between, returns way 0 for every set.
- R2: `vic_vld` is high in exactly the cycle after a cycle with `vic_req` high, and low otherwise. The returned `vic_way` is computed from the state as it was before any touch presented in the same cycle as the request.
- R3: A hit (`hit_vld` high, with no fill in that cycle) clears the counter of `hit_way` in set `hit_set` and adds one to every other counter of that set. Counters of other sets keep their values.
- R4: A fill updates the recency state exactly as a hit on `fill_way` in `fill_set` does. As a result, the filled way is never the victim of a request on that set issued in the next cycle.
- R5: With counters in use, the victim is the way holding the largest count in the requested set. When several ways share that count, the lowest-numbered of them is chosen.
- R6: An age counter that holds its maximum value, 2^CNT_W-1, keeps that value when it is aged. It never wraps to a low count.
- R7: When `hit_vld` and `fill_vld` are both high in one cycle, only the fill updates the state and the hit is discarded.
- R8: With `NUM_WAYS` = 2, each set holds one bit, cleared by reset. A touch of way 0 sets the bit to 1 and a touch of way 1 clears it to 0. A bit of 0 returns way 0 as the victim and a bit of 1 returns way 1.
- R9: With `NUM_WAYS` = 2, a hit updates the bit in the same way as a fill, so the way just hit is protected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_vld | input | 1 | A hit is reported this cycle |
| hit_set | input | SET_W | Set index of the hit |
| hit_way | input | WAY_W | Way that hit |
| fill_vld | input | 1 | A fill is reported this cycle |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way that received the new line |
| vic_req | input | 1 | Victim request for `vic_set` |
| vic_set | input | SET_W | Set index of the victim request |
| vic_way | output | WAY_W | Chosen victim way, valid when `vic_vld` is high |
| vic_vld | output | 1 | Victim answer valid, one cycle after the request |

## Verification
A touch presented at one clock edge changes the state at that edge. A victim request presented at a later edge sees that new state, and its answer appears on `vic_way` and `vic_vld` one edge after the request. A request made in the same cycle as a touch is therefore answered from the state before the touch. The bench drives each stimulus at a falling edge. It computes the expected victim from its own model before applying that cycle's touch to the model, and it compares at the next falling edge, after the single register stage. Cycles with no request are checked for a low `vic_vld` at the same point.

// File: rtl/lru_age_pkg.sv
// Package lru_age_pkg
// Shared definitions for the replacement unit. It selects how recency is
// tracked from the associativity. It assumes nothing about clocking.
package lru_age_pkg;

    typedef enum logic {
        TRACK_AGING = 1'b0,
        TRACK_BIT   = 1'b1
    } lru_track_e;

    // Pick the tracking scheme: one bit per set for two ways, counters otherwise.
    function automatic lru_track_e track_for(int unsigned ways);
        return (ways == 2) ? TRACK_BIT : TRACK_AGING;
    endfunction

endpackage

// File: rtl/lru_touch_mux.sv
// Module lru_touch_mux
// Merges the hit and fill strobes into one touch command. A fill takes
// priority over a hit in the same cycle, and the hit is then dropped.
// The block is purely combinational.
module lru_touch_mux #(
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             hit_vld,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_vld,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    output logic             t_vld,
    output logic [SET_W-1:0] t_set,
    output logic [WAY_W-1:0] t_way
);

    // Choose the touch source, giving the fill priority.
    always_comb begin
        t_vld = fill_vld | hit_vld;
        if (fill_vld) begin
            t_set = fill_set;
            t_way = fill_way;
        end else begin
            t_set = hit_set;
            t_way = hit_way;
        end
    end

endmodule

// File: rtl/lru_age_bank.sv
// Module lru_age_bank
// Holds one saturating age counter per way per set. A touch clears the
// counter of the touched way and ages the rest of that set. It returns the
// counter row of the set being read, combinationally.
// It assumes NUM_SETS is a power of two and the reset is synchronous.
module lru_age_bank #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int SET_W    = 2,
    parameter int WAY_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            t_vld,
    input  logic [SET_W-1:0]                t_set,
    input  logic [WAY_W-1:0]                t_way,
    input  logic [SET_W-1:0]                rd_set,
    output logic [NUM_WAYS-1:0][CNT_W-1:0]  rd_row
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [NUM_WAYS-1:0][CNT_W-1:0] rows [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [NUM_WAYS-1:0][CNT_W-1:0] row_q;
        logic                           sel;

        assign sel     = t_vld && (t_set == SET_W'(s));
        assign rows[s] = row_q;

        // Clear the touched way and age the others, saturating at the maximum.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (sel) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (t_way == WAY_W'(w)) begin
                        row_q[w] <= '0;
                    end else if (row_q[w] != CNT_MAX) begin
                        row_q[w] <= row_q[w] + 1'b1;
                    end
                end
            end
        end
    end

    // Read out the row of the requested set.
    always_comb begin
        rd_row = rows[rd_set];
    end

endmodule

// File: rtl/lru_oldest_pick.sv
// Module lru_oldest_pick
// Returns the index of the largest counter in a row. Among equal counts the
// lowest index wins. The block is purely combinational and its depth is
// linear in NUM_WAYS.
module lru_oldest_pick #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0][CNT_W-1:0] row,
    output logic [WAY_W-1:0]               oldest
);

    logic [CNT_W-1:0] best_val;

    // Scan upward. A strict compare keeps the earliest of any tied maxima.
    always_comb begin
        oldest   = '0;
        best_val = row[0];
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (row[i] > best_val) begin
                best_val = row[i];
                oldest   = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/lru_bit_bank.sv
// Module lru_bit_bank
// Two-way recency store with one bit per set. Touching way 0 sets the bit
// and touching way 1 clears it. The bit read out is the victim way.
// It assumes NUM_SETS is a power of two and the reset is synchronous.
module lru_bit_bank #(
    parameter int NUM_SETS = 4,
    parameter int SET_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t_vld,
    input  logic [SET_W-1:0] t_set,
    input  logic             t_way,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_bit
);

    logic [NUM_SETS-1:0] bits_q;

    // Point the bit of the touched set at the way that was not touched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (t_vld) begin
            bits_q[t_set] <= ~t_way;
        end
    end

    // Read the bit of the requested set.
    always_comb begin
        rd_bit = bits_q[rd_set];
    end

endmodule

// File: rtl/lru_age_unit.sv
// Module lru_age_unit
// Top of the replacement unit. It merges the touch strobes, keeps recency
// with either per-way age counters or one bit per set (chosen from
// NUM_WAYS), and registers the victim answer one cycle after the request.
// It assumes NUM_SETS and NUM_WAYS are powers of two, NUM_WAYS >= 2 and
// CNT_W >= 1. The reset is synchronous and active low.
module lru_age_unit
    import lru_age_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_vld,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_vld,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             vic_req,
    input  logic [SET_W-1:0] vic_set,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_vld
);

    localparam lru_track_e TRACK = track_for(NUM_WAYS);

    logic             t_vld;
    logic [SET_W-1:0] t_set;
    logic [WAY_W-1:0] t_way;
    logic [WAY_W-1:0] pick_way;

    lru_touch_mux #(
        .SET_W(SET_W),
        .WAY_W(WAY_W)
    ) u_touch (
        .hit_vld (hit_vld),
        .hit_set (hit_set),
        .hit_way (hit_way),
        .fill_vld(fill_vld),
        .fill_set(fill_set),
        .fill_way(fill_way),
        .t_vld   (t_vld),
        .t_set   (t_set),
        .t_way   (t_way)
    );

    if (TRACK == TRACK_BIT) begin : g_bit
        logic rd_bit;

        lru_bit_bank #(
            .NUM_SETS(NUM_SETS),
            .SET_W   (SET_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .t_vld (t_vld),
            .t_set (t_set),
            .t_way (t_way[0]),
            .rd_set(vic_set),
            .rd_bit(rd_bit)
        );

        assign pick_way = WAY_W'(rd_bit);
    end else begin : g_age
        logic [NUM_WAYS-1:0][CNT_W-1:0] rd_row;

        lru_age_bank #(
            .NUM_SETS(NUM_SETS),
            .NUM_WAYS(NUM_WAYS),
            .CNT_W   (CNT_W),
            .SET_W   (SET_W),
            .WAY_W   (WAY_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .t_vld (t_vld),
            .t_set (t_set),
            .t_way (t_way),
            .rd_set(vic_set),
            .rd_row(rd_row)
        );

        lru_oldest_pick #(
            .NUM_WAYS(NUM_WAYS),
            .CNT_W   (CNT_W),
            .WAY_W   (WAY_W)
        ) u_pick (
            .row   (rd_row),
            .oldest(pick_way)
        );
    end

    // Register the victim answer. The way holds its value between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_vld <= 1'b0;
            vic_way <= '0;
        end else begin
            vic_vld <= vic_req;
            if (vic_req) begin
                vic_way <= pick_way;
            end
        end
    end

endmodule

// File: rtl/lru_age_chk.sv
// Module lru_age_chk
// Checker for lru_age_unit, attached by bind. It checks the response timing
// of victim requests and that a freshly touched way is not named as the
// victim one cycle later.
module lru_age_chk #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_vld,
    input logic [SET_W-1:0] hit_set,
    input logic [WAY_W-1:0] hit_way,
    input logic             fill_vld,
    input logic [SET_W-1:0] fill_set,
    input logic [WAY_W-1:0] fill_way,
    input logic             vic_req,
    input logic [SET_W-1:0] vic_set,
    input logic [WAY_W-1:0] vic_way,
    input logic             vic_vld
);

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_vld);  // R2

    AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_vld);  // R2

    AST_FILL_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld ##1 (vic_req && vic_set == $past(fill_set)))
        |=> (vic_way != $past(fill_way, 2)));  // R4

    AST_HIT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_vld && !fill_vld) ##1 (vic_req && vic_set == $past(hit_set)))
        |=> (vic_way != $past(hit_way, 2)));  // R3

    AST_HIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((fill_vld && hit_vld) ##1 (vic_req && vic_set == $past(fill_set)))
        |=> (vic_way != $past(fill_way, 2)));  // R7

endmodule

bind lru_age_unit lru_age_chk #(
    .NUM_SETS(NUM_SETS),
    .NUM_WAYS(NUM_WAYS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vld (hit_vld),
    .hit_set (hit_set),
    .hit_way (hit_way),
    .fill_vld(fill_vld),
    .fill_set(fill_set),
    .fill_way(fill_way),
    .vic_req (vic_req),
    .vic_set (vic_set),
    .vic_way (vic_way),
    .vic_vld (vic_vld)
);

// File: tb/sim_lru_age_unit.sv
`timescale 1ns/1ps
// Bench: a four-way unit (u0) with 2-bit counters and a two-way unit (u1),
// both with four sets and driven by the same stimulus. Expected victims come
// from an arithmetic model of the requirements.
module sim_lru_age_unit;

    localparam int NS   = 4;
    localparam int NW   = 4;
    localparam int CW   = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_vld = 1'b0, fill_vld = 1'b0, vic_req = 1'b0;
    logic [1:0] hit_set = '0, fill_set = '0, vic_set = '0;
    logic [1:0] hit_way = '0, fill_way = '0;
    logic [1:0] w4_way;
    logic       w4_vld;
    logic [0:0] w2_way;
    logic       w2_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int age [NS][NW];
    bit rbit [NS];

    always #2.5 clk = ~clk;

    lru_age_unit #(.NUM_SETS(NS), .NUM_WAYS(NW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .hit_vld(hit_vld), .hit_set(hit_set), .hit_way(hit_way),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way),
        .vic_req(vic_req), .vic_set(vic_set),
        .vic_way(w4_way), .vic_vld(w4_vld)
    );

    lru_age_unit #(.NUM_SETS(NS), .NUM_WAYS(2), .CNT_W(CW)) u1 (
        .clk(clk), .rst_n(rst_n),
        .hit_vld(hit_vld), .hit_set(hit_set), .hit_way(hit_way[0:0]),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way[0:0]),
        .vic_req(vic_req), .vic_set(vic_set),
        .vic_way(w2_way), .vic_vld(w2_vld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp4(input int s);
        int best = 0;
        for (int w = 1; w < NW; w++) if (age[s][w] > age[s][best]) best = w;
        return best;
    endfunction

    task automatic touch(input int s, input int w);
        for (int i = 0; i < NW; i++) begin
            if (i == w) age[s][i] = 0;
            else if (age[s][i] < CMAX) age[s][i] = age[s][i] + 1;
        end
        rbit[s] = ((w % 2) == 0);
    endtask

    // One cycle: drive at a falling edge, compare at the next falling edge.
    task automatic step(input bit hv, input int hs, input int hw,
                        input bit fv, input int fs, input int fw,
                        input bit qv, input int qs,
                        input string t4, input string t2);
        int e4;
        int e2;
        e4 = exp4(qs);
        e2 = rbit[qs];
        hit_vld = hv;  hit_set = 2'(hs);  hit_way = 2'(hw);
        fill_vld = fv; fill_set = 2'(fs); fill_way = 2'(fw);
        vic_req = qv;  vic_set = 2'(qs);
        @(negedge clk);
        if (qv) begin
            chk(w4_vld == 1'b1, "R2", int'(w4_vld), 1);
            chk(int'(w4_way) == e4, t4, int'(w4_way), e4);
            chk(w2_vld == 1'b1, "R2", int'(w2_vld), 1);
            chk(int'(w2_way) == e2, t2, int'(w2_way), e2);
        end else begin
            chk(w4_vld == 1'b0 && w2_vld == 1'b0, "R2", int'(w4_vld | w2_vld), 0);
        end
        if (fv) touch(fs, fw);
        else if (hv) touch(hs, hw);
        hit_vld = 1'b0; fill_vld = 1'b0; vic_req = 1'b0;
    endtask

    task automatic query(input int s, input string t4, input string t2);
        step(0, 0, 0, 0, 0, 0, 1, s, t4, t2);
    endtask

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < NS; s++) begin
            rbit[s] = 1'b0;
            for (int w = 0; w < NW; w++) age[s][w] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, way 0 in every set for both variants.
        for (int s = 0; s < NS; s++) query(s, "R1", "R1");

        // R6: three ages saturate at 3; a hit on way 1 must not wrap them.
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R3", "R9");
        step(1, 1, 1, 0, 0, 0, 0, 0, "R3", "R9");
        query(1, "R6", "R9");

        // R5: tie handling on set 2.
        step(1, 2, 3, 0, 0, 0, 0, 0, "R3", "R9");
        query(2, "R5", "R9");
        step(1, 2, 0, 0, 0, 0, 0, 0, "R3", "R9");
        query(2, "R5", "R9");

        // R7: fill and hit together on set 3, only the fill counts.
        step(1, 3, 1, 1, 3, 2, 0, 0, "R7", "R7");
        query(3, "R7", "R8");

        // R8 and R9: two-way bit driven by a fill and then by a hit.
        step(0, 0, 0, 1, 0, 0, 0, 0, "R4", "R8");
        query(0, "R4", "R8");
        step(1, 0, 1, 0, 0, 0, 0, 0, "R3", "R9");
        query(0, "R3", "R9");

        // R2: request in the same cycle as a touch sees the old state.
        step(1, 0, 2, 0, 0, 0, 1, 0, "R2", "R2");
        query(0, "R3", "R9");

        // Sweep with mixed hits, fills, collisions and requests (R3 R4 R5 R6 R7 R8 R9).
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], int'(lf[2:1]), int'(lf[4:3]),
                 lf[5] & lf[6], int'(lf[8:7]), int'(lf[10:9]),
                 lf[11] | lf[12], int'(lf[14:13]), "R5", "R8");
        end
        for (int s = 0; s < NS; s++) query(s, "R6", "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule